// File: doc/BRIEF.md
# Double-Width Funnel Right Shifter

This unit is the right-funnel datapath of a processor ALU. It moves a destination word right by a variable amount and refills the vacated high positions with the low bits of a second source word, so that a chain of such operations performs a shift across several machine words. The operand width is either 16 or 32 bits, chosen per operation, and the shift amount is the low five bits of an 8-bit count.

Besides the result word the unit produces the six arithmetic flags and a flag-write-enable that tells the register stage whether the flags should be committed. A count whose low five bits are zero performs no operation. A count that reaches or exceeds a 16-bit operand's width has no architecturally defined result. For that case the unit makes a fixed choice and raises a status bit so that a checker can tell the case apart. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `fsh_funnel_right`

## Requirements
- R1: The effective shift amount N is count_i modulo 32; the upper three count bits never change any output.
- R2: When N is 0, the result equals dst_i, every flag output equals its input, flag_we_o is 0 and undef_o is 0.
- R3: In 32-bit mode (wide_i=1) with N from 1 to 31, result bit i equals dst_i bit i+N for i below 32-N, and result bits 32-N to 31 equal fill_i bits 0 to N-1 in order.
- R4: In 16-bit mode (wide_i=0) with N from 1 to 15, result bits 0 to 15 follow the same rule using the low 16 bits of dst_i and fill_i, and result bits 16 to 31 equal dst_i bits 16 to 31.
- R5: For a valid nonzero N, cf_o equals dst_i bit N-1.
- R6: For a valid nonzero N, sf_o equals result bit 31 in 32-bit mode and bit 15 in 16-bit mode, and zf_o is 1 exactly when the result bits of the selected width are all zero.
- R7: For a valid nonzero N, pf_o is 1 exactly when result bits 0 to 7 hold an even number of ones.
- R8: For every operation, of_o and af_o equal of_i and af_i.
- R9: In 16-bit mode with N from 16 to 31, the result equals dst_i, all flag outputs equal their inputs, undef_o is 1 and flag_we_o is 1.
- R10: flag_we_o is 1 for every nonzero N.
- R11: Outputs change on the rising clock edge following the one at which the inputs are sampled; while rst_n is low at an edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dst_i | input | 32 | Destination word being shifted |
| fill_i | input | 32 | Word whose low bits refill the vacated top |
| count_i | input | 8 | Shift count, used modulo 32 |
| wide_i | input | 1 | 1 selects 32-bit operands, 0 selects 16-bit |
| cf_i | input | 1 | Current carry flag |
| sf_i | input | 1 | Current sign flag |
| zf_i | input | 1 | Current zero flag |
| pf_i | input | 1 | Current parity flag |
| of_i | input | 1 | Current overflow flag |
| af_i | input | 1 | Current auxiliary-carry flag |
| res_o | output | 32 | Result word |
| cf_o | output | 1 | Carry: last bit shifted out |
| sf_o | output | 1 | Sign of the result |
| zf_o | output | 1 | Result is zero at the selected width |
| pf_o | output | 1 | Even parity of the result's low byte |
| of_o | output | 1 | Overflow, passed through |
| af_o | output | 1 | Auxiliary carry, passed through |
| flag_we_o | output | 1 | Flags should be committed |
| undef_o | output | 1 | Count too large for a 16-bit operand |

## Verification
The assertions assume every input is a known 0 or 1 at each sampling edge and that wide_i together with the count describes the operation actually wanted in that cycle; they relate each registered output to the inputs one edge earlier, so they need a held value across one clock only. The bench drives all inputs on the falling edge, holds them through the next rising edge and reads outputs one nanosecond after it, so each input set is stable for a full sampling window and no check depends on event ordering at the edge.

// File: rtl/fsh_pkg.sv
// Package: shared widths and the flag bundle of the funnel right shifter.
// Assumes: a 32-bit machine word with a 16-bit narrow mode.
package fsh_pkg;

    localparam int unsigned FSH_DATA_W = 32;
    localparam int unsigned FSH_HALF_W = 16;
    localparam int unsigned FSH_CNT_W  = 8;
    localparam int unsigned FSH_PAR_W  = 8;

    // Arithmetic flags carried as one bundle through the unit.
    typedef struct packed {
        logic cf;
        logic sf;
        logic zf;
        logic pf;
        logic ovf;
        logic aux;
    } fsh_flags_t;

endpackage

// File: rtl/fsh_count_decode.sv
// Count decoder: reduces the raw count to the effective shift amount and
// classifies it as zero, valid, or too large for the selected width.
// Assumes: DATA_W is a power of two and HALF_W is DATA_W/2.
module fsh_count_decode #(
    parameter int unsigned CNT_W  = fsh_pkg::FSH_CNT_W,
    parameter int unsigned DATA_W = fsh_pkg::FSH_DATA_W,
    parameter int unsigned HALF_W = fsh_pkg::FSH_HALF_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             wide_i,
    output logic [SH_W-1:0]  amt_o,
    output logic             zero_o,
    output logic             oversize_o
);

    logic unused_cnt_hi;

    // Modulo reduction: keep only the low bits of the count.
    always_comb begin
        amt_o         = count_i[SH_W-1:0];
        unused_cnt_hi = ^count_i[CNT_W-1:SH_W];
    end

    // Classification of the effective amount against the operand width.
    always_comb begin
        zero_o     = (amt_o == '0);
        oversize_o = !wide_i && (amt_o >= SH_W'(HALF_W));
    end

endmodule

// File: rtl/fsh_funnel.sv
// Funnel core: forms both the 32-bit and the 16-bit right-funnel results
// and the bit shifted out last; the caller picks one by width.
// Assumes: amt_i is nonzero and below the width whenever the outputs are used.
module fsh_funnel #(
    parameter int unsigned DATA_W = fsh_pkg::FSH_DATA_W,
    parameter int unsigned HALF_W = fsh_pkg::FSH_HALF_W,
    localparam int unsigned SH_W  = $clog2(DATA_W),
    localparam int unsigned WI_W  = SH_W + 1
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] fill_i,
    input  logic [SH_W-1:0]   amt_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    logic [2*DATA_W-1:0] cat_wide;
    logic [2*HALF_W-1:0] cat_narrow;
    logic [DATA_W-1:0]   res_wide;
    logic [HALF_W-1:0]   res_narrow;

    // Join fill above destination for both widths.
    always_comb begin
        cat_wide   = {fill_i, dst_i};
        cat_narrow = {fill_i[HALF_W-1:0], dst_i[HALF_W-1:0]};
    end

    // One selector per result bit, 32-bit window.
    for (genvar g = 0; g < DATA_W; g++) begin : g_wide
        logic [WI_W-1:0] idx;
        always_comb begin
            idx         = WI_W'(g) + WI_W'(amt_i);
            res_wide[g] = cat_wide[idx];
        end
    end

    // One selector per result bit, 16-bit window (index wraps harmlessly
    // when the amount is out of range; that result is discarded).
    for (genvar g = 0; g < HALF_W; g++) begin : g_narrow
        logic [SH_W-1:0] idx;
        always_comb begin
            idx           = SH_W'(g) + amt_i;
            res_narrow[g] = cat_narrow[idx];
        end
    end

    // Width select; narrow mode keeps the upper destination half.
    always_comb begin
        if (wide_i) res_o = res_wide;
        else        res_o = {dst_i[DATA_W-1:HALF_W], res_narrow};
    end

    // Last bit shifted out is destination bit amt-1.
    always_comb begin
        cout_o = dst_i[amt_i - 1'b1];
    end

endmodule

// File: rtl/fsh_flag_gen.sv
// Result flags: sign and zero at the selected width, parity of the low byte.
// Assumes: HALF_W and PAR_W do not exceed DATA_W.
module fsh_flag_gen #(
    parameter int unsigned DATA_W = fsh_pkg::FSH_DATA_W,
    parameter int unsigned HALF_W = fsh_pkg::FSH_HALF_W,
    parameter int unsigned PAR_W  = fsh_pkg::FSH_PAR_W
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              wide_i,
    output logic              sf_o,
    output logic              zf_o,
    output logic              pf_o
);

    // Sign and zero follow the operand width; parity is even-ones.
    always_comb begin
        sf_o = wide_i ? res_i[DATA_W-1] : res_i[HALF_W-1];
        zf_o = wide_i ? (res_i == '0) : (res_i[HALF_W-1:0] == '0);
        pf_o = ~^res_i[PAR_W-1:0];
    end

endmodule

// File: rtl/fsh_funnel_right.sv
// Top: double-width funnel right shifter with registered outputs.
// Picks between the shifted result and a pass-through of destination and
// flags, and registers result, flags, write-enable and the undefined status.
// Assumes: inputs are stable around each rising edge; reset is synchronous.
module fsh_funnel_right
    import fsh_pkg::*;
#(
    parameter int unsigned DATA_W = FSH_DATA_W,
    parameter int unsigned HALF_W = FSH_HALF_W,
    parameter int unsigned CNT_W  = FSH_CNT_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] fill_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wide_i,
    input  logic              cf_i,
    input  logic              sf_i,
    input  logic              zf_i,
    input  logic              pf_i,
    input  logic              of_i,
    input  logic              af_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cf_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              pf_o,
    output logic              of_o,
    output logic              af_o,
    output logic              flag_we_o,
    output logic              undef_o
);

    logic [SH_W-1:0]   amt;
    logic              amt_zero;
    logic              amt_big;
    logic [DATA_W-1:0] shifted;
    logic              shift_cout;
    logic              new_sf, new_zf, new_pf;
    fsh_flags_t        flags_in, flags_nxt, flags_q;
    logic [DATA_W-1:0] res_nxt, res_q;
    logic              we_q, undef_q;

    fsh_count_decode #(.CNT_W(CNT_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_dec (
        .count_i    (count_i),
        .wide_i     (wide_i),
        .amt_o      (amt),
        .zero_o     (amt_zero),
        .oversize_o (amt_big)
    );

    fsh_funnel #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_core (
        .dst_i  (dst_i),
        .fill_i (fill_i),
        .amt_i  (amt),
        .wide_i (wide_i),
        .res_o  (shifted),
        .cout_o (shift_cout)
    );

    fsh_flag_gen #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_flags (
        .res_i  (shifted),
        .wide_i (wide_i),
        .sf_o   (new_sf),
        .zf_o   (new_zf),
        .pf_o   (new_pf)
    );

    // Bundle the incoming flags.
    always_comb begin
        flags_in = '{cf: cf_i, sf: sf_i, zf: zf_i, pf: pf_i, ovf: of_i, aux: af_i};
    end

    // Choose pass-through for no-op and oversize counts, else the shift.
    always_comb begin
        if (amt_zero || amt_big) begin
            res_nxt   = dst_i;
            flags_nxt = flags_in;
        end else begin
            res_nxt   = shifted;
            flags_nxt = '{cf: shift_cout, sf: new_sf, zf: new_zf, pf: new_pf,
                          ovf: of_i, aux: af_i};
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            we_q    <= 1'b0;
            undef_q <= 1'b0;
        end else begin
            res_q   <= res_nxt;
            flags_q <= flags_nxt;
            we_q    <= !amt_zero;
            undef_q <= amt_big;
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        res_o     = res_q;
        cf_o      = flags_q.cf;
        sf_o      = flags_q.sf;
        zf_o      = flags_q.zf;
        pf_o      = flags_q.pf;
        of_o      = flags_q.ovf;
        af_o      = flags_q.aux;
        flag_we_o = we_q;
        undef_o   = undef_q;
    end

    assert_noop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i[SH_W-1:0] == '0) |=> (res_o == $past(dst_i) && !flag_we_o && !undef_o
                                      && cf_o == $past(cf_i) && zf_o == $past(zf_i)));

    assert_oversize_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_i && count_i[SH_W-1]) |=> (undef_o && flag_we_o && res_o == $past(dst_i)
                                         && sf_o == $past(sf_i)));

    assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |=> (res_o[DATA_W-1:HALF_W] == $past(dst_i[DATA_W-1:HALF_W])));

    assert_passthru_ovf_aux_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (of_o == $past(of_i) && af_o == $past(af_i)));

    assert_we_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i[SH_W-1:0] != '0) |=> flag_we_o);

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && count_i[SH_W-1:0] != '0) |=> (zf_o == (res_o == '0)));

    assert_carry_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && count_i[SH_W-1:0] == SH_W'(1)) |=> (cf_o == $past(dst_i[0])));

endmodule

// File: tb/tb_fsh_funnel_right.sv
`timescale 1ns/1ps
module tb_fsh_funnel_right;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dst_i = '0, fill_i = '0;
    logic [7:0]  count_i = '0;
    logic        wide_i = 1'b1;
    logic        cf_i = 0, sf_i = 0, zf_i = 0, pf_i = 0, of_i = 0, af_i = 0;
    logic [31:0] res_o;
    logic        cf_o, sf_o, zf_o, pf_o, of_o, af_o, flag_we_o, undef_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    fsh_funnel_right dut (
        .clk(clk), .rst_n(rst_n), .dst_i(dst_i), .fill_i(fill_i), .count_i(count_i),
        .wide_i(wide_i), .cf_i(cf_i), .sf_i(sf_i), .zf_i(zf_i), .pf_i(pf_i),
        .of_i(of_i), .af_i(af_i), .res_o(res_o), .cf_o(cf_o), .sf_o(sf_o),
        .zf_o(zf_o), .pf_o(pf_o), .of_o(of_o), .af_o(af_o),
        .flag_we_o(flag_we_o), .undef_o(undef_o)
    );

    // Reference model from the requirements; returns {res,cf,sf,zf,pf,of,af,we,undef}.
    function automatic logic [39:0] model(input logic [31:0] d, input logic [31:0] f,
                                          input logic [7:0] c, input logic w,
                                          input logic [5:0] fl);
        int n = int'(c % 8'd32);
        int sz = w ? 32 : 16;
        logic [31:0] r = d;
        logic [5:0]  o = fl;
        logic we = (n != 0);
        logic ud = (n >= sz);
        int ones = 0;
        if (n != 0 && !ud) begin
            for (int i = 0; i < sz; i++)
                r[i] = (i < sz - n) ? d[i + n] : f[i + n - sz];
            o[5] = d[n - 1];
            o[4] = r[sz - 1];
            o[3] = 1'b1;
            for (int i = 0; i < sz; i++) if (r[i]) o[3] = 1'b0;
            for (int i = 0; i < 8; i++) if (r[i]) ones++;
            o[2] = (ones % 2 == 0);
        end
        return {r, o, we, ud};
    endfunction

    task automatic run_op(input string tag, input logic [31:0] d, input logic [31:0] f,
                          input logic [7:0] c, input logic w, input logic [5:0] fl);
        logic [39:0] exp_v, act_v;
        @(negedge clk);
        dst_i = d; fill_i = f; count_i = c; wide_i = w;
        {cf_i, sf_i, zf_i, pf_i, of_i, af_i} = fl;
        exp_v = model(d, f, c, w, fl);
        @(posedge clk); #1;
        act_v = {res_o, cf_o, sf_o, zf_o, pf_o, of_o, af_o, flag_we_o, undef_o};
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic test_reset();   // R11
        rst_n = 1'b0;
        dst_i = 32'hFFFF_FFFF; count_i = 8'd3;
        repeat (2) @(posedge clk); #1;
        n_checks++;
        if ({res_o, cf_o, sf_o, zf_o, pf_o, of_o, af_o, flag_we_o, undef_o} !== '0) begin
            n_fail++;
            $display("FAIL R11: actual %h expected 0",
                     {res_o, cf_o, sf_o, zf_o, pf_o, of_o, af_o, flag_we_o, undef_o});
        end
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic test_wide();    // R3 R5 R6 R7 R8 R10
        run_op("R3", 32'h8765_4321, 32'hABCD_EF01, 8'd4, 1'b1, 6'b000011);
        run_op("R5", 32'h0000_0001, 32'h0000_0000, 8'd1, 1'b1, 6'b000000);
        run_op("R3", 32'h1234_5678, 32'hFEDC_BA98, 8'd31, 1'b1, 6'b111100);
        run_op("R6", 32'h0000_00F0, 32'h0000_0000, 8'd8, 1'b1, 6'b000010);
        run_op("R7", 32'h0000_0700, 32'h8000_0000, 8'd8, 1'b1, 6'b000001);
    endtask

    task automatic test_narrow();  // R4 R5 R6
        run_op("R4", 32'hCAFE_8001, 32'h5555_1234, 8'd1, 1'b0, 6'b000000);
        run_op("R4", 32'hDEAD_BEEF, 32'h0000_8001, 8'd15, 1'b0, 6'b010001);
        run_op("R6", 32'hFFFF_00F0, 32'hFFFF_0000, 8'd8, 1'b0, 6'b000000);
    endtask

    task automatic test_modulo();  // R1
        run_op("R1", 32'h8765_4321, 32'hABCD_EF01, 8'hE4, 1'b1, 6'b000000);
        run_op("R1", 32'h0F0F_1234, 32'h0000_A5A5, 8'h63, 1'b0, 6'b101010);
    endtask

    task automatic test_noop();    // R2 R1
        run_op("R2", 32'h1357_9BDF, 32'hFFFF_FFFF, 8'd0, 1'b1, 6'b101101);
        run_op("R2", 32'h2468_ACE0, 32'hFFFF_FFFF, 8'h20, 1'b0, 6'b010010);
        run_op("R2", 32'h2468_ACE0, 32'h1111_1111, 8'hC0, 1'b1, 6'b111111);
    endtask

    task automatic test_oversize(); // R9 R10
        run_op("R9", 32'hA5A5_5A5A, 32'h1234_5678, 8'd16, 1'b0, 6'b110011);
        run_op("R9", 32'hA5A5_5A5A, 32'h1234_5678, 8'd31, 1'b0, 6'b001100);
        run_op("R10", 32'h0000_0000, 32'h0000_0000, 8'd16, 1'b1, 6'b000000);
    endtask

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        test_wide();
        test_narrow();
        test_modulo();
        test_noop();
        test_oversize();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule